// File: doc/BRIEF.md
# Addressed Serial Control Register Front End

This block is the serial control port of a configurable output driver. A host sends 16-bit frames over a three-wire link: an active-low select `spi_cs_n`, a serial clock `spi_sclk` and a data line `spi_sdi`. Each frame starts with a three-bit device address. The block accepts a frame only when that address equals the three address strap pins, so up to eight drivers can share one bus. An accepted write loads the driver's control fields:

- a four-bit range code
- clear select
- output enable
- clear
- external-resistor select

A soft reset bit in the frame returns every field to zero and is never stored. All serial inputs are synchronized into the system clock `clk`. Falling edges of the serial clock are detected in that domain.

A receive state machine tracks each frame with four states: `RX_IDLE`, `RX_SHIFT`, `RX_FULL` and `RX_OVER`. Its transitions are:

- **start:** `RX_IDLE` to `RX_SHIFT`, when select falls.
- **shift:** `RX_SHIFT` stays in `RX_SHIFT` on each falling serial-clock edge.
- **fill:** `RX_SHIFT` to `RX_FULL`, on the 16th falling edge.
- **overrun:** `RX_FULL` to `RX_OVER`, on a 17th falling edge.
- **commit:** `RX_FULL` to `RX_IDLE`, when select rises. Only this transition delivers a frame.
- **abort:** `RX_SHIFT` or `RX_OVER` to `RX_IDLE`, when select rises. The frame is discarded.

A level-sensitive reset pin `rst_pin_n` clears the fields while it is low. A hardware-select pin `hw_sel` bypasses the serial register entirely. While it is high, the range and the enable come from pins.

Top module: `ctlp_top`

## Requirements
- R1: A frame is shifted MSB first, one bit per falling edge of `spi_sclk`. It takes effect only when `spi_cs_n` rises after exactly 16 falling edges. Frames of 15 or 17 bits leave the outputs unchanged.
- R2: Frame bits 15:13 must equal `addr_strap` for the frame to be accepted. A frame carrying any other address changes nothing.
- R3: An accepted write loads the fields from these frame bits:
  - `range_code` from bits 10:7
  - `clr_sel` from bit 6
  - `out_en` from bit 5
  - `clr` from bit 4
  - `rext_sel` from bit 3
- R4: A frame with bit 12 set (the read flag) changes nothing. A frame with any of the must-be-zero bits 11, 1 or 0 set also changes nothing.
- R5: An accepted write with bit 2 (soft reset) set clears every field to zero and applies none of the frame's other fields. A later write loads normally.
- R6: After `rst_n` is released, all fields are zero and `out_tristate` is 1.
- R7: In serial mode, while `rst_pin_n` is low, all fields are zero and any frame sent is ignored. After the pin is released, the fields stay zero until a new write arrives.
- R8: While `hw_sel` is 1:
  - `range_code` follows `hw_range` and `out_en` follows `hw_outen`.
  - `clr_sel`, `clr` and `rext_sel` read 0.
  - Frames and `rst_pin_n` are ignored.
  - When `hw_sel` returns to 0, the serially written values reappear.
- R9: `out_tristate` is 1 exactly when `out_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock; data sampled on its falling edge |
| spi_cs_n | input | 1 | Frame select, active low; rising edge ends a frame |
| spi_sdi | input | 1 | Serial data, MSB first |
| addr_strap | input | 3 | Device address straps |
| rst_pin_n | input | 1 | Level reset of the control fields, active low |
| hw_sel | input | 1 | 1 selects pin control instead of the serial register |
| hw_range | input | 4 | Range code used in pin control |
| hw_outen | input | 1 | Output enable used in pin control |
| range_code | output | 4 | Registered range code |
| clr_sel | output | 1 | Registered clear select |
| out_en | output | 1 | Registered output enable |
| clr | output | 1 | Registered clear |
| rext_sel | output | 1 | Registered external-resistor select |
| out_tristate | output | 1 | 1 when both current and voltage outputs are tristated |

## Verification
The bench sends frames of 15 and 17 bits. A receiver that counted edges loosely would commit these frames, corrupting the range and enable fields. It sends read-flagged writes, writes with reserved bits set and writes with a mismatched address. A decoder that skipped one of these checks would load fields it should have left alone. It sets the soft reset bit together with nonzero fields, which catches a design that applies those fields or stores the reset bit. It holds the level reset low while a frame arrives, then toggles pin control while frames and resets are sent. A wrong mode multiplexer would leak serial values into pin mode, or lose the serially written values on return.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 3;
    localparam int RANGE_W  = 4;

    localparam int ADDR_LSB = FRAME_W - ADDR_W;   // 13
    localparam int RW_BIT   = ADDR_LSB - 1;       // 12
    localparam int RSV_HI   = RW_BIT - 1;         // 11
    localparam int RANGE_LSB = RSV_HI - RANGE_W;  // 7
    localparam int CLRSEL_BIT = RANGE_LSB - 1;    // 6
    localparam int OUTEN_BIT  = CLRSEL_BIT - 1;   // 5
    localparam int CLR_BIT    = OUTEN_BIT - 1;    // 4
    localparam int REXT_BIT   = CLR_BIT - 1;      // 3
    localparam int SRST_BIT   = REXT_BIT - 1;     // 2

    typedef struct packed {
        logic [RANGE_W-1:0] range;
        logic               clr_sel;
        logic               out_en;
        logic               clr;
        logic               rext_sel;
    } ctl_fields_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_FULL  = 2'd2,
        RX_OVER  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ctlp_rx.sv
module ctlp_rx
    import ctlp_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          cs_n_s,
    input  logic          sdi_s,
    output logic [FW-1:0] frame_word,
    output logic          frame_ok
);
    localparam int CNT_W = $clog2(FW + 1);

    rx_state_t  state_q, state_d;
    logic       sclk_q, cs_q;
    logic [CNT_W-1:0] cnt_q;
    logic       sclk_fall, cs_rise, cs_fall;

    assign sclk_fall = sclk_q & ~sclk_s;
    assign cs_rise   = ~cs_q & cs_n_s;
    assign cs_fall   = cs_q & ~cs_n_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (cs_fall) state_d = RX_SHIFT;
            RX_SHIFT: begin
                if (cs_rise)
                    state_d = RX_IDLE;
                else if (sclk_fall && cnt_q == CNT_W'(FW - 1))
                    state_d = RX_FULL;
            end
            RX_FULL: begin
                if (cs_rise)        state_d = RX_IDLE;
                else if (sclk_fall) state_d = RX_OVER;
            end
            RX_OVER:  if (cs_rise) state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            cs_q       <= 1'b1;
            cnt_q      <= '0;
            frame_word <= '0;
            frame_ok   <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            cs_q     <= cs_n_s;
            frame_ok <= (state_q == RX_FULL) && cs_rise;
            if (state_q == RX_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == RX_SHIFT && sclk_fall && !cs_rise) begin
                frame_word <= {frame_word[FW-2:0], sdi_s};
                cnt_q      <= cnt_q + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FW)) else $error("bit count past frame length"); // R1
    AST_OK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> state_q == RX_IDLE) else $error("commit outside idle"); // R1
endmodule

// File: rtl/ctlp_regs.sv
module ctlp_regs
    import ctlp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_word,
    input  logic               frame_ok,
    input  logic [ADDR_W-1:0]  addr_strap,
    input  logic               lvl_rst_n,
    input  logic               hw_sel,
    input  logic [RANGE_W-1:0] hw_range,
    input  logic               hw_outen,
    output ctl_fields_t        fields_o,
    output logic               tristate_o
);
    ctl_fields_t soft_q, pin_f, sel_f;
    logic        addr_hit, fmt_ok, accept;

    assign addr_hit = frame_word[FRAME_W-1:ADDR_LSB] == addr_strap;
    assign fmt_ok   = !frame_word[RW_BIT] && !frame_word[RSV_HI]
                      && frame_word[1:0] == 2'b00;
    assign accept   = frame_ok && addr_hit && fmt_ok && !hw_sel && lvl_rst_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= '0;
        end else if (!hw_sel) begin
            if (!lvl_rst_n) begin
                soft_q <= '0;
            end else if (accept) begin
                if (frame_word[SRST_BIT]) begin
                    soft_q <= '0;
                end else begin
                    soft_q.range    <= frame_word[RANGE_LSB +: RANGE_W];
                    soft_q.clr_sel  <= frame_word[CLRSEL_BIT];
                    soft_q.out_en   <= frame_word[OUTEN_BIT];
                    soft_q.clr      <= frame_word[CLR_BIT];
                    soft_q.rext_sel <= frame_word[REXT_BIT];
                end
            end
        end
    end

    always_comb begin
        pin_f        = '0;
        pin_f.range  = hw_range;
        pin_f.out_en = hw_outen;
        sel_f        = hw_sel ? pin_f : soft_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_o   <= '0;
            tristate_o <= 1'b1;
        end else begin
            fields_o   <= sel_f;
            tristate_o <= ~sel_f.out_en;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && lvl_rst_n) |=> $stable(soft_q)) else $error("fields moved without write"); // R4
    AST_LVL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_sel && !lvl_rst_n) |=> soft_q == '0) else $error("level reset not applied"); // R7
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && frame_word[SRST_BIT]) |=> soft_q == '0) else $error("soft reset not applied"); // R5
    AST_PIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        hw_sel |=> $stable(soft_q)) else $error("serial state touched in pin mode"); // R8
endmodule

// File: rtl/ctlp_top.sv
module ctlp_top
    import ctlp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_sdi,
    input  logic [ADDR_W-1:0]  addr_strap,
    input  logic               rst_pin_n,
    input  logic               hw_sel,
    input  logic [RANGE_W-1:0] hw_range,
    input  logic               hw_outen,
    output logic [RANGE_W-1:0] range_code,
    output logic               clr_sel,
    output logic               out_en,
    output logic               clr,
    output logic               rext_sel,
    output logic               out_tristate
);
    logic [3:0]         sync_q;
    logic [FRAME_W-1:0] frame_word;
    logic               frame_ok;
    ctl_fields_t        fields;

    ctlp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sclk, spi_cs_n, spi_sdi, rst_pin_n}),
        .q     (sync_q)
    );

    ctlp_rx #(.FW(FRAME_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sync_q[3]),
        .cs_n_s     (sync_q[2]),
        .sdi_s      (sync_q[1]),
        .frame_word (frame_word),
        .frame_ok   (frame_ok)
    );

    ctlp_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_word (frame_word),
        .frame_ok   (frame_ok),
        .addr_strap (addr_strap),
        .lvl_rst_n  (sync_q[0]),
        .hw_sel     (hw_sel),
        .hw_range   (hw_range),
        .hw_outen   (hw_outen),
        .fields_o   (fields),
        .tristate_o (out_tristate)
    );

    assign range_code = fields.range;
    assign clr_sel    = fields.clr_sel;
    assign out_en     = fields.out_en;
    assign clr        = fields.clr;
    assign rext_sel   = fields.rext_sel;
endmodule

// File: tb/sim_ctlp_top.sv
module sim_ctlp_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam int NVEC       = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_sdi = 1'b0;
    logic [2:0] addr_strap = 3'b101;
    logic       rst_pin_n = 1'b1, hw_sel = 1'b0, hw_outen = 1'b0;
    logic [3:0] hw_range = 4'd0;
    logic [3:0] range_code;
    logic       clr_sel, out_en, clr, rext_sel, out_tristate;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlp_top u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_sdi(spi_sdi), .addr_strap(addr_strap), .rst_pin_n(rst_pin_n),
        .hw_sel(hw_sel), .hw_range(hw_range), .hw_outen(hw_outen),
        .range_code(range_code), .clr_sel(clr_sel), .out_en(out_en),
        .clr(clr), .rext_sel(rext_sel), .out_tristate(out_tristate)
    );

    // {req[4], nbits[5], addr[3], rw, resv{b11,b1,b0}[3], range[4], cs, oe, cl, rx, srst, exp{range,cs,oe,cl,rx}[8]}
    localparam logic [32:0] VEC [NVEC] = '{
        {4'd3, 5'd16, 3'b101, 1'b0, 3'b000, 4'b0101, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'b0101_0101}, // R3 write
        {4'd2, 5'd16, 3'b011, 1'b0, 3'b000, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'b0101_0101}, // R2 other address
        {4'd3, 5'd16, 3'b101, 1'b0, 3'b000, 4'b1010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'b1010_1010}, // R3 write
        {4'd4, 5'd16, 3'b101, 1'b1, 3'b000, 4'b0011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'b1010_1010}, // R4 read flag
        {4'd4, 5'd16, 3'b101, 1'b0, 3'b100, 4'b0011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'b1010_1010}, // R4 bit 11
        {4'd4, 5'd16, 3'b101, 1'b0, 3'b001, 4'b0011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'b1010_1010}, // R4 bit 0
        {4'd1, 5'd15, 3'b101, 1'b0, 3'b000, 4'b0011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'b1010_1010}, // R1 short
        {4'd1, 5'd17, 3'b101, 1'b0, 3'b000, 4'b0011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'b1010_1010}, // R1 long
        {4'd3, 5'd16, 3'b101, 1'b0, 3'b000, 4'b1100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'b1100_0110}, // R3 write
        {4'd5, 5'd16, 3'b101, 1'b0, 3'b000, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'b0000_0000}, // R5 soft reset
        {4'd5, 5'd16, 3'b101, 1'b0, 3'b000, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'b0001_1100}, // R5 after reset
        {4'd4, 5'd16, 3'b101, 1'b0, 3'b010, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'b0001_1100}  // R4 bit 1
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input logic [2:0] a, input logic rw,
                                       input logic [2:0] rsv, input logic [3:0] rg,
                                       input logic cs, input logic oe, input logic cl,
                                       input logic rx, input logic sr);
        return {a, rw, rsv[2], rg, cs, oe, cl, rx, sr, rsv[1], rsv[0]};
    endfunction

    task automatic send(input logic [15:0] w, input int nbits);
        spi_cs_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int i = 0; i < nbits; i++) begin
            spi_sdi  = (i < 16) ? w[15-i] : 1'b0;
            spi_sclk = 1'b1;
            wait_clk(HALF_BIT);
            spi_sclk = 1'b0;
            wait_clk(HALF_BIT);
        end
        spi_cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic chk(input string req, input logic [7:0] exp);
        logic [7:0] got;
        got = {range_code, clr_sel, out_en, clr, rext_sel};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s fields got=%b exp=%b", req, got, exp);
        end
        checks++;
        if (out_tristate !== ~exp[2]) begin
            errors++;
            $display("FAIL R9 (%s) tristate got=%b exp=%b", req, out_tristate, ~exp[2]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired got=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(3);
        chk("R6 during reset", 8'h00);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R6 after reset", 8'h00);

        for (int k = 0; k < NVEC; k++) begin
            logic [32:0] v;
            v = VEC[k];
            send(mk(v[23:21], v[20], v[19:17], v[16:13], v[12], v[11], v[10], v[9], v[8]),
                 int'(v[28:24]));
            chk($sformatf("R%0d vec%0d", v[32:29], k), v[7:0]);
        end

        // R2: another strap value selects another address
        addr_strap = 3'b010;
        send(mk(3'b101, 1'b0, 3'b000, 4'b0111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 16);
        chk("R2 old address after strap change", 8'b0001_1100);
        send(mk(3'b010, 1'b0, 3'b000, 4'b0111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 16);
        chk("R2 new address", 8'b0111_0100);

        // R7: level reset clears and blocks frames
        rst_pin_n = 1'b0;
        wait_clk(6);
        chk("R7 pin low", 8'h00);
        send(mk(3'b010, 1'b0, 3'b000, 4'b1001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0), 16);
        chk("R7 frame while low", 8'h00);
        rst_pin_n = 1'b1;
        wait_clk(6);
        chk("R7 released", 8'h00);
        send(mk(3'b010, 1'b0, 3'b000, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0), 16);
        chk("R7 write after release", 8'b0110_0101);

        // R8: pin control
        hw_range = 4'b1001;
        hw_outen = 1'b0;
        hw_sel   = 1'b1;
        wait_clk(4);
        chk("R8 pin mode off", 8'b1001_0000);
        send(mk(3'b010, 1'b0, 3'b000, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0), 16);
        chk("R8 frame ignored", 8'b1001_0000);
        rst_pin_n = 1'b0;
        wait_clk(6);
        rst_pin_n = 1'b1;
        hw_outen  = 1'b1;
        hw_range  = 4'b0011;
        wait_clk(6);
        chk("R8 pin mode on", 8'b0011_0100);
        hw_sel = 1'b0;
        wait_clk(4);
        chk("R8 serial values restored", 8'b0110_0101);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule